// File: doc/BRIEF.md
# Machine and Supervisor Control Register Unit

This block holds the machine-level and supervisor-level control registers of a RISC-V style core and serves the read and write half of CSR instructions. A 12-bit register address, write data and a write strobe come in. Read data and an illegal-access flag go out. The read path is combinational from the current register state, so the read value is available in the same cycle. A write changes state at the next rising clock edge.

Each register accepts only the fields that software may change. The status register keeps its old privilege field or translation-mode field when the value written for that field is not legal. The read-only dirty summary bit at the top of the status word is not stored; it is computed from the floating-point and extension state fields. The supervisor status, interrupt-pending and interrupt-enable registers hold no state of their own. They are views of the machine registers: the supervisor status view masks fields, and the supervisor interrupt views are filtered through the interrupt delegation register.

Parameters: `XLEN` (32 or 64), `HAS_EXT` (whether the extension-state field is writable) and `MTVEC_RST` (reset value of the machine trap vector).

Top module: `csr_unit`

## Requirements
- R1: After reset every register reads 0, except the machine trap vector (0x305), which reads `MTVEC_RST` with its two low bits cleared and truncated to XLEN.
- R2: A write to mstatus (0x300) changes only these bits: SIE bit 1, MIE bit 3, SPIE bit 5, MPIE bit 7, SPP bit 8, FS bits 14:13, MPRV bit 17 and PUM bit 18. XS bits 16:15 are also writable, but only when HAS_EXT is 1. All other bits read 0, except the fields covered by R3, R4 and R5.
- R3: The previous-privilege field MPP (mstatus bits 12:11) takes the written value only when that value is 0, 1 or 3. A written value of 2 leaves the field unchanged.
- R4: The translation-mode field (mstatus bits 28:24) takes the written value only when the value is legal for XLEN: 0 is always legal, 8 only when XLEN is 32, and 9 or 10 only when XLEN is 64. Any other value leaves the field unchanged.
- R5: Bit XLEN-1 of mstatus and of sstatus reads 1 exactly when FS is 3 or XS is 3. Writes to this bit have no effect.
- R6: In mip (0x344), software can write only bits 1 and 5. All other bits read 0.
- R7: mie (0x304) keeps only bits 1, 3, 5, 7, 9 and 12. mideleg (0x303) keeps only bits 1, 5, 9 and 12.
- R8: sstatus (0x100) reads the mstatus bits 1, 5, 8, 13 to 16 and 18, plus the bit from R5. A write through sstatus changes only SIE, SPIE, SPP, FS, PUM, and XS when it is writable.
- R9: sip (0x144) reads as mip AND mideleg, and sie (0x104) reads as mie AND mideleg. A write through either one changes only the bit positions that are set in mideleg, and within those positions only the bits R6 or R7 allow.
- R10: mtvec (0x305) and stvec (0x105) always read with bits 1:0 equal to 0. The two counter-enable registers (0x320 and 0x321) keep only bits 2:0.
- R11: mscratch 0x340, sscratch 0x140, mepc 0x341, sepc 0x141, mcause 0x342 and scause 0x142 store all XLEN bits. A write becomes visible on reads in the cycle after the write strobe.
- R12: Any address outside those listed in R1 to R11 raises `csr_illegal_o` in the same cycle. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Write data |
| csr_we_i | input | 1 | Write strobe |
| csr_rdata_o | output | XLEN | Read data for `csr_addr_i` |
| csr_illegal_o | output | 1 | Address not implemented |

## Verification
The bench builds two instances side by side and drives both with the same inputs. One uses XLEN 64 with the extension field writable. The other uses XLEN 32 without it. Together they cover every branch of the translation-mode legality rule, the dirty summary bit at both bit 63 and bit 31, and an XS field that is writable in one instance and fixed at zero in the other. Each instance is compared against its own behavioural model on every clock, first with directed writes and then with random traffic that includes unimplemented addresses.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_SIE     = 12'h104;
  localparam logic [11:0] A_SIP     = 12'h144;
  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_MIDELEG = 12'h303;
  localparam logic [11:0] A_MIE     = 12'h304;
  localparam logic [11:0] A_MIP     = 12'h344;
  localparam logic [11:0] A_MTVEC   = 12'h305;
  localparam logic [11:0] A_STVEC   = 12'h105;

  // status register masks
  localparam logic [63:0] ST_BASE_M = 64'h0000_0000_0006_61AA;
  localparam logic [63:0] ST_XS_M   = 64'h0000_0000_0001_8000;
  localparam logic [63:0] ST_SVIEW  = 64'h0000_0000_0005_E122;

  // interrupt register masks
  localparam logic [63:0] IP_WMASK  = 64'h0000_0000_0000_0022;
  localparam logic [63:0] IE_MASK   = 64'h0000_0000_0000_12AA;
  localparam logic [63:0] DG_MASK   = 64'h0000_0000_0000_1222;

  // plain registers: index 0 is the machine trap vector
  localparam int unsigned NPLAIN = 10;

  typedef struct packed {
    logic mstatus;
    logic sstatus;
    logic mip;
    logic sip;
    logic mie;
    logic sie;
    logic mideleg;
  } csr_sel_t;

  function automatic logic [11:0] plain_addr(input int unsigned i);
    case (i)
      0:       return A_MTVEC;
      1:       return A_STVEC;
      2:       return 12'h340;
      3:       return 12'h140;
      4:       return 12'h341;
      5:       return 12'h141;
      6:       return 12'h342;
      7:       return 12'h142;
      8:       return 12'h320;
      default: return 12'h321;
    endcase
  endfunction

  function automatic logic [63:0] plain_mask(input int unsigned i);
    if (i <= 1)      return ~64'h3;
    else if (i >= 8) return 64'h7;
    else             return '1;
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old_v,
                                        input logic [63:0] new_v,
                                        input logic [63:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic priv_ok(input logic [1:0] p);
    return p != 2'b10;
  endfunction

  function automatic logic vm_ok(input int unsigned xlen, input logic [4:0] vm);
    if (vm == 5'd0) return 1'b1;
    if (xlen == 32) return vm == 5'd8;
    return (vm == 5'd9) || (vm == 5'd10);
  endfunction

  function automatic logic st_dirty(input logic [63:0] st);
    return (&st[14:13]) || (&st[16:15]);
  endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_unit_pkg::*;
(
  input  logic [11:0]       addr_i,
  output csr_sel_t          sel_o,
  output logic [NPLAIN-1:0] plain_sel_o,
  output logic              hit_o
);

  always_comb begin
    sel_o = '0;
    case (addr_i)
      A_MSTATUS: sel_o.mstatus = 1'b1;
      A_SSTATUS: sel_o.sstatus = 1'b1;
      A_MIP:     sel_o.mip     = 1'b1;
      A_SIP:     sel_o.sip     = 1'b1;
      A_MIE:     sel_o.mie     = 1'b1;
      A_SIE:     sel_o.sie     = 1'b1;
      A_MIDELEG: sel_o.mideleg = 1'b1;
      default:   sel_o = '0;
    endcase
  end

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    assign plain_sel_o[g] = (addr_i == plain_addr(g));
  end

  assign hit_o = (|sel_o) | (|plain_sel_o);

endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg
  import csr_unit_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          HAS_EXT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_m_i,
  input  logic        wr_s_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] st_q_o,
  output logic        sd_o
);

  localparam logic [63:0] WMASK = ST_BASE_M | (HAS_EXT ? ST_XS_M : 64'h0);

  logic [63:0] st_d;

  always_comb begin
    st_d = st_q_o;
    if (wr_m_i) begin
      st_d = merge(st_q_o, wdata_i, WMASK);
      if (priv_ok(wdata_i[12:11])) st_d[12:11] = wdata_i[12:11];
      if (vm_ok(XLEN, wdata_i[28:24])) st_d[28:24] = wdata_i[28:24];
    end else if (wr_s_i) begin
      st_d = merge(st_q_o, wdata_i, WMASK & ST_SVIEW);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q_o <= '0;
    else         st_q_o <= st_d;
  end

  assign sd_o = st_dirty(st_q_o);

endmodule

// File: rtl/csr_irq_regs.sv
module csr_irq_regs
  import csr_unit_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  csr_sel_t    sel_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] mip_q_o,
  output logic [63:0] mie_q_o,
  output logic [63:0] deleg_q_o
);

  logic [63:0] mip_d, mie_d, deleg_d;

  always_comb begin
    mip_d   = mip_q_o;
    mie_d   = mie_q_o;
    deleg_d = deleg_q_o;
    if (we_i && sel_i.mip) mip_d = merge(mip_q_o, wdata_i, IP_WMASK);
    if (we_i && sel_i.sip) mip_d = merge(mip_q_o, wdata_i, IP_WMASK & deleg_q_o);
    if (we_i && sel_i.mie) mie_d = merge(mie_q_o, wdata_i, IE_MASK);
    if (we_i && sel_i.sie) mie_d = merge(mie_q_o, wdata_i, IE_MASK & deleg_q_o);
    if (we_i && sel_i.mideleg) deleg_d = merge(deleg_q_o, wdata_i, DG_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mip_q_o   <= '0;
      mie_q_o   <= '0;
      deleg_q_o <= '0;
    end else begin
      mip_q_o   <= mip_d;
      mie_q_o   <= mie_d;
      deleg_q_o <= deleg_d;
    end
  end

endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_unit_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter bit          HAS_EXT   = 1'b1,
  parameter logic [63:0] MTVEC_RST = 64'h0000_0000_0000_0100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            csr_we_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o
);

  localparam logic [63:0] XMASK   = (XLEN >= 64) ? {64{1'b1}} : ((64'd1 << XLEN) - 64'd1);
  localparam logic [63:0] MTV_EFF = MTVEC_RST & ~64'h3 & XMASK;

  // named internal events and state for the checker
  csr_sel_t          sel;
  logic [NPLAIN-1:0] plain_sel;
  logic              hit;
  logic              wr_fire;
  logic [63:0]       wdata64;
  logic [63:0]       st_q, mip_q, mie_q, deleg_q;
  logic              sd;
  logic [63:0]       sd_word;
  logic [63:0]       rd64;
  logic [63:0]       plain_q [NPLAIN];

  assign wdata64 = 64'(csr_wdata_i);
  assign wr_fire = csr_we_i & hit;

  csr_addr_decode dec_i (
    .addr_i      (csr_addr_i),
    .sel_o       (sel),
    .plain_sel_o (plain_sel),
    .hit_o       (hit)
  );

  csr_status_reg #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) status_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_m_i  (csr_we_i & sel.mstatus),
    .wr_s_i  (csr_we_i & sel.sstatus),
    .wdata_i (wdata64),
    .st_q_o  (st_q),
    .sd_o    (sd)
  );

  csr_irq_regs irq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (csr_we_i),
    .sel_i     (sel),
    .wdata_i   (wdata64),
    .mip_q_o   (mip_q),
    .mie_q_o   (mie_q),
    .deleg_q_o (deleg_q)
  );

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    localparam logic [63:0] RST_V = (g == 0) ? MTV_EFF : 64'h0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        plain_q[g] <= RST_V;
      else if (wr_fire && plain_sel[g])
        plain_q[g] <= merge(plain_q[g], wdata64, plain_mask(g));
    end
  end

  assign sd_word = 64'(sd) << (XLEN - 1);

  always_comb begin
    rd64 = '0;
    if (sel.mstatus) rd64 = st_q | sd_word;
    if (sel.sstatus) rd64 = (st_q & ST_SVIEW) | sd_word;
    if (sel.mip)     rd64 = mip_q;
    if (sel.sip)     rd64 = mip_q & deleg_q;
    if (sel.mie)     rd64 = mie_q;
    if (sel.sie)     rd64 = mie_q & deleg_q;
    if (sel.mideleg) rd64 = deleg_q;
    for (int i = 0; i < NPLAIN; i++)
      if (plain_sel[i]) rd64 = plain_q[i];
  end

  assign csr_rdata_o   = rd64[XLEN-1:0];
  assign csr_illegal_o = ~hit;

endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk
  import csr_unit_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [11:0]     csr_addr_i,
  input logic            csr_we_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            csr_illegal_o,
  input logic [63:0]     st_q,
  input logic [63:0]     mip_q,
  input logic [63:0]     mie_q,
  input logic [63:0]     deleg_q
);

  // R12
  illegal_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_illegal_o && csr_we_i) |=> ($stable(st_q) && $stable(mip_q) &&
                                     $stable(mie_q) && $stable(deleg_q)));

  // R3
  mpp_never_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[12:11] != 2'b10);

  // R6
  mip_only_sw_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mip_q & ~IP_WMASK) == 64'h0);

  // R7
  deleg_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deleg_q & ~DG_MASK) == 64'h0 && (mie_q & ~IE_MASK) == 64'h0);

  // R9
  sip_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_SIP) |-> csr_rdata_o == XLEN'(mip_q & deleg_q));

  // R5
  sd_summary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_MSTATUS) |-> csr_rdata_o[XLEN-1] == (st_q[14:13] == 2'b11 || st_q[16:15] == 2'b11));

  // R10
  vec_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_MTVEC || csr_addr_i == A_STVEC) |-> csr_rdata_o[1:0] == 2'b00);

endmodule

bind csr_unit csr_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_addr_i    (csr_addr_i),
  .csr_we_i      (csr_we_i),
  .csr_rdata_o   (csr_rdata_o),
  .csr_illegal_o (csr_illegal_o),
  .st_q          (st_q),
  .mip_q         (mip_q),
  .mie_q         (mie_q),
  .deleg_q       (deleg_q)
);

// File: tb/csr_unit_tb_top.sv
`timescale 1ns/1ps
module csr_unit_tb_top;

  localparam logic [63:0] MTV = 64'h0000_0000_8000_0107;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wd = '0;
  logic        we = 1'b0;
  logic [63:0] rd64;
  logic [31:0] rd32;
  logic        ill64, ill32;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csr_unit #(.XLEN(64), .HAS_EXT(1'b1), .MTVEC_RST(MTV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wd),
    .csr_we_i(we), .csr_rdata_o(rd64), .csr_illegal_o(ill64));

  csr_unit #(.XLEN(32), .HAS_EXT(1'b0), .MTVEC_RST(MTV)) dut32_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wd[31:0]),
    .csr_we_i(we), .csr_rdata_o(rd32), .csr_illegal_o(ill32));

  // ---------------- behavioural model ----------------
  logic [63:0] mreg [int];

  function automatic int xl(int c);  return (c == 0) ? 64 : 32; endfunction
  function automatic bit has_x(int c); return c == 0; endfunction
  function automatic logic [63:0] xm(int c);
    return (c == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
  endfunction
  function automatic int key(int c, logic [11:0] a); return c * 4096 + int'(a); endfunction

  function automatic bit known(logic [11:0] a);
    return a inside {12'h300, 12'h100, 12'h344, 12'h144, 12'h304, 12'h104, 12'h303,
                     12'h305, 12'h105, 12'h340, 12'h140, 12'h341, 12'h141,
                     12'h342, 12'h142, 12'h320, 12'h321};
  endfunction

  function automatic string req_of(logic [11:0] a);
    case (a)
      12'h300: return "R2";
      12'h100: return "R8";
      12'h344: return "R6";
      12'h144, 12'h104: return "R9";
      12'h304, 12'h303: return "R7";
      12'h305, 12'h105, 12'h320, 12'h321: return "R10";
      default: return known(a) ? "R11" : "R12";
    endcase
  endfunction

  function automatic void model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 4096; a++)
        if (known(12'(a))) mreg[key(c, 12'(a))] = 64'h0;
      mreg[key(c, 12'h305)] = MTV & ~64'h3 & xm(c);
    end
  endfunction

  function automatic logic [63:0] model_read(int c, logic [11:0] a);
    logic [63:0] s = mreg[key(c, 12'h300)];
    logic [63:0] v;
    bit sd = (s[14:13] == 2'b11) || (s[16:15] == 2'b11);
    case (a)
      12'h300: begin v = s; v[xl(c)-1] = sd; end
      12'h100: begin
        v = '0;
        v[1] = s[1]; v[5] = s[5]; v[8] = s[8]; v[16:13] = s[16:13]; v[18] = s[18];
        v[xl(c)-1] = sd;
      end
      12'h144: v = mreg[key(c, 12'h344)] & mreg[key(c, 12'h303)];
      12'h104: v = mreg[key(c, 12'h304)] & mreg[key(c, 12'h303)];
      default: v = known(a) ? mreg[key(c, a)] : 64'h0;
    endcase
    return v & xm(c);
  endfunction

  function automatic void write_status(int c, logic [63:0] d, bit sview);
    logic [63:0] s = mreg[key(c, 12'h300)];
    int pos[$];
    logic [4:0] vm;
    if (sview) pos = '{1, 5, 8, 13, 14, 18};
    else       pos = '{1, 3, 5, 7, 8, 13, 14, 17, 18};
    if (has_x(c)) begin pos.push_back(15); pos.push_back(16); end
    foreach (pos[k]) s[pos[k]] = d[pos[k]];
    if (!sview) begin
      if (d[12:11] != 2'd2) s[12:11] = d[12:11];
      vm = d[28:24];
      if (vm == 0 || (xl(c) == 32 && vm == 8) || (xl(c) == 64 && (vm == 9 || vm == 10)))
        s[28:24] = vm;
    end
    mreg[key(c, 12'h300)] = s;
  endfunction

  function automatic void upd(int c, logic [11:0] a, logic [63:0] d, logic [63:0] m);
    mreg[key(c, a)] = (mreg[key(c, a)] & ~m) | (d & m);
  endfunction

  function automatic void model_write(int c, logic [11:0] a, logic [63:0] d0);
    logic [63:0] d = d0 & xm(c);
    logic [63:0] dg = mreg[key(c, 12'h303)];
    case (a)
      12'h300: write_status(c, d, 1'b0);
      12'h100: write_status(c, d, 1'b1);
      12'h344: upd(c, 12'h344, d, 64'h22);
      12'h144: upd(c, 12'h344, d, 64'h22 & dg);
      12'h304: upd(c, 12'h304, d, 64'h12AA);
      12'h104: upd(c, 12'h304, d, 64'h12AA & dg);
      12'h303: upd(c, 12'h303, d, 64'h1222);
      12'h305, 12'h105: mreg[key(c, a)] = d & ~64'h3;
      12'h320, 12'h321: mreg[key(c, a)] = d & 64'h7;
      default: if (known(a)) mreg[key(c, a)] = d;
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic chk(int c, string tag);
    logic [63:0] act = (c == 0) ? rd64 : 64'(rd32);
    logic        act_i = (c == 0) ? ill64 : ill32;
    logic [63:0] exp = model_read(c, addr);
    logic        exp_i = !known(addr);
    string t = (tag == "") ? req_of(addr) : tag;
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s xlen%0d addr %h: rdata %h expected %h", t, xl(c), addr, act, exp);
    end
    n_checks++;
    if (act_i !== exp_i) begin
      n_err++;
      $display("FAIL R12 xlen%0d addr %h: illegal %b expected %b", xl(c), addr, act_i, exp_i);
    end
  endtask

  task automatic op(logic [11:0] a, logic [63:0] d, bit w, string tag);
    addr = a; wd = d; we = w;
    #1;
    chk(0, tag);
    chk(1, tag);
    @(posedge clk);
    if (w) begin model_write(0, a, d); model_write(1, a, d); end
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, string tag); op(a, 64'h0, 1'b0, tag); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  logic [11:0] alist [21] = '{12'h300, 12'h100, 12'h344, 12'h144, 12'h304, 12'h104,
                              12'h303, 12'h305, 12'h105, 12'h340, 12'h140, 12'h341,
                              12'h141, 12'h342, 12'h142, 12'h320, 12'h321,
                              12'h000, 12'h302, 12'h7B0, 12'h345};

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    foreach (alist[i]) rd(alist[i], "R1");

    // R2 / R3: writable status fields and privilege legality
    op(12'h300, '1, 1'b1, "R2");
    rd(12'h300, "R2");
    op(12'h300, 64'h0000_0000_0000_1000, 1'b1, "R3");
    rd(12'h300, "R3");
    op(12'h300, 64'h0000_0000_0000_0800, 1'b1, "R3");
    rd(12'h300, "R3");

    // R4: translation mode legality
    op(12'h300, 64'h0000_0000_0900_0000, 1'b1, "R4"); rd(12'h300, "R4");
    op(12'h300, 64'h0000_0000_0800_0000, 1'b1, "R4"); rd(12'h300, "R4");
    op(12'h300, 64'h0000_0000_0A00_0000, 1'b1, "R4"); rd(12'h300, "R4");
    op(12'h300, 64'h0000_0000_1F00_0000, 1'b1, "R4"); rd(12'h300, "R4");
    op(12'h300, 64'h0, 1'b1, "R4");                   rd(12'h300, "R4");

    // R5: dirty summary
    op(12'h300, 64'h8000_0000_8000_0000, 1'b1, "R5"); rd(12'h300, "R5");
    op(12'h300, 64'h0000_0000_0000_6000, 1'b1, "R5"); rd(12'h300, "R5"); rd(12'h100, "R5");
    op(12'h300, 64'h0000_0000_0001_8000, 1'b1, "R5"); rd(12'h300, "R5"); rd(12'h100, "R5");

    // R8: supervisor status view
    op(12'h300, 64'h0000_0000_0002_1888, 1'b1, "R8");
    op(12'h100, '1, 1'b1, "R8");
    rd(12'h300, "R8"); rd(12'h100, "R8");
    op(12'h100, 64'h0, 1'b1, "R8");
    rd(12'h300, "R8");

    // R6 / R7
    op(12'h344, '1, 1'b1, "R6"); rd(12'h344, "R6");
    op(12'h304, '1, 1'b1, "R7"); rd(12'h304, "R7");
    op(12'h303, '1, 1'b1, "R7"); rd(12'h303, "R7");

    // R9: views filtered by delegation
    op(12'h344, 64'h0, 1'b1, "R9");
    op(12'h304, 64'h0, 1'b1, "R9");
    op(12'h303, 64'h20, 1'b1, "R9");
    op(12'h144, '1, 1'b1, "R9"); rd(12'h344, "R9"); rd(12'h144, "R9");
    op(12'h104, '1, 1'b1, "R9"); rd(12'h304, "R9"); rd(12'h104, "R9");
    op(12'h303, 64'h0, 1'b1, "R9");
    op(12'h144, 64'h0, 1'b1, "R9"); rd(12'h344, "R9");

    // R10
    op(12'h305, '1, 1'b1, "R10"); rd(12'h305, "R10");
    op(12'h105, 64'h1237, 1'b1, "R10"); rd(12'h105, "R10");
    op(12'h320, '1, 1'b1, "R10"); rd(12'h320, "R10");
    op(12'h321, 64'hA, 1'b1, "R10"); rd(12'h321, "R10");

    // R11
    op(12'h340, 64'hDEAD_BEEF_0123_4567, 1'b1, "R11"); rd(12'h340, "R11");
    op(12'h141, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, "R11"); rd(12'h141, "R11");
    op(12'h342, 64'h8000_0000_0000_000B, 1'b1, "R11"); rd(12'h342, "R11");

    // R12: unimplemented addresses
    op(12'h302, '1, 1'b1, "R12");
    op(12'h7B0, '1, 1'b1, "R12");
    foreach (alist[i]) rd(alist[i], "R12");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a = alist[$urandom_range(0, 20)];
      logic [63:0] d = {$urandom, $urandom};
      op(a, d, 1'($urandom_range(0, 1)), "");
    end

    finish_run();
  end

endmodule